// File: doc/BRIEF.md
# Receive-Buffer Backpressure Jam Controller

This block protects a receive packet buffer on a half-duplex link. It compares the buffer's free space, given in bytes, against a high-water threshold held in kilobyte units. When free space falls below that threshold, it raises a jam request toward the MAC transmitter. The transmitter's collisions then hold off the remote station. Each jam lasts for a fixed period. A 4-bit code selects the period from a non-linear scale that runs from 5 µs to 600 µs. The period is counted on a one-microsecond tick strobe supplied by the chip.

An 8-bit configuration byte drives the block. Bits 7:4 hold the threshold in 1024-byte units, and bits 3:0 hold the duration code. The host register that supplies this byte is expected to reset to 0x37, which means a 3 KB threshold and 200 µs. The package exports this value as `JAM_CFG_DEFAULT`.

At the end of each period the block checks the buffer again. If space is still short, a fresh period starts at once and the jam request stays high. Otherwise the block returns to idle. Dropping the enable input aborts any jam immediately.

Top module: `bp_jam_ctrl`

## Requirements
- R1: While enabled and idle, a clock edge that sees free space strictly less than cfg[7:4] × 1024 bytes starts a jam period, and jam_req is high from that edge on. Free space equal to the threshold does not start one.
- R2: With a threshold field of 0, no jam ever starts, whatever the free-space value.
- R3: A jam period lasts D tick pulses, where D is selected by cfg[3:0]: codes 0..15 give 5, 10, 15, 25, 50, 100, 150, 200, 250, 300, 350, 400, 450, 500, 550 and 600.
- R4: Clock cycles without a tick pulse do not advance the jam period.
- R5: If free space is still below the threshold at the edge where a period ends, a new period begins at that edge and jam_req stays high without a gap.
- R6: If free space is not below the threshold when a period ends, the controller returns to idle and jam_req falls.
- R7: A change to cfg during a period does not alter that period's length. The next period uses the cfg value present at its start.
- R8: When en is low, jam_req is low in the same cycle, and the controller is idle after the next edge. No jam starts while en is low.
- R9: busy is high exactly when en is high and either a jam is active or free space is below the threshold.
- R10: After reset, jam_req is low and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| free_bytes | input | FREE_W (16) | Free space in the receive buffer, in bytes |
| cfg | input | 8 | [7:4] threshold in KB, [3:0] duration code |
| jam_req | output | 1 | Request to jam the half-duplex line |
| busy | output | 1 | Jam active or about to start |

## Verification
The bench measures the length of each period in ticks for the smallest code, the largest code, the default code and both sides of the break in the scale between codes 3 and 4. A wrong table entry, or an off-by-one in the down-counter, changes those lengths.

It also places free space exactly at the threshold and one byte under it. A design that compares with "less or equal", or that scales the threshold by the wrong unit, starts a jam one step early or late.

Further cases cover:
- a duration code rewritten in the middle of a period, which a design that does not latch the duration would cut short or stretch;
- continuous shortage, where a design that passes through idle would show a one-cycle gap in the jam;
- removing enable in the middle of a jam, where a design with a registered gate would leave jam_req high for one cycle.

// File: rtl/jam_pkg.sv
// Shared constants, types and the duration scale for the backpressure jam controller.
// Assumes the duration scale never exceeds 600 ticks, so CNT_W bits suffice.
package jam_pkg;

    localparam int CNT_W = 10;
    localparam int JAM_MAX_US = 600;
    localparam logic [7:0] JAM_CFG_DEFAULT = 8'h37;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_JAM  = 1'b1
    } jam_state_e;

    // Map a 4-bit duration code to a tick count: three 5-step codes, 25, then 50-step codes.
    function automatic logic [CNT_W-1:0] jam_time_us(input logic [3:0] code);
        int c;
        c = int'(code);
        if (c < 3)
            return CNT_W'(5 * (c + 1));
        else if (c == 3)
            return CNT_W'(25);
        else
            return CNT_W'(50 * (c - 3));
    endfunction

endpackage

// File: rtl/jam_cfg_decode.sv
// Splits the configuration byte into a byte-scaled threshold and a duration in ticks.
// Assumes one threshold unit equals 2**UNIT_LG bytes; purely combinational.
module jam_cfg_decode
    import jam_pkg::*;
#(
    parameter int UNIT_LG = 10,
    localparam int THR_W  = 4 + UNIT_LG
) (
    input  logic [7:0]       cfg,
    output logic [THR_W-1:0] thr_bytes,
    output logic [CNT_W-1:0] dur_ticks
);

    // Scale the threshold nibble to bytes by shifting it left.
    always_comb begin
        thr_bytes = {cfg[7:4], {UNIT_LG{1'b0}}};
    end

    // Look up the period length for the duration code.
    always_comb begin
        dur_ticks = jam_time_us(cfg[3:0]);
    end

endmodule

// File: rtl/jam_level_cmp.sv
// Flags a shortage when free buffer space is strictly below the threshold.
// Assumes both operands are unsigned; zero-extends both to a common width.
module jam_level_cmp #(
    parameter int FREE_W = 16,
    parameter int THR_W  = 14,
    localparam int CMP_W = ((FREE_W > THR_W) ? FREE_W : THR_W) + 1
) (
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [THR_W-1:0]  thr_bytes,
    output logic              below
);

    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] thr_x;

    // Extend both operands and compare them.
    always_comb begin
        free_x = CMP_W'(free_bytes);
        thr_x  = CMP_W'(thr_bytes);
        below  = free_x < thr_x;
    end

endmodule

// File: rtl/jam_timer.sv
// Down-counter for one jam period, advanced only on tick pulses.
// Assumes load and clr are not asserted together; clr takes precedence if they are.
module jam_timer
    import jam_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load, clear or count down the remaining ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && tick && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Signal the final tick of a running period.
    always_comb begin
        done = run && tick && (cnt_q == CNT_W'(1));
        cnt  = cnt_q;
    end

endmodule

// File: rtl/bp_jam_ctrl.sv
// Backpressure jam controller: starts, re-arms and aborts jam periods from buffer free space.
// Assumes us_tick is a single-cycle pulse and cfg is driven from a host register reset to 0x37.
module bp_jam_ctrl
    import jam_pkg::*;
#(
    parameter int FREE_W  = 16,
    parameter int UNIT_LG = 10,
    localparam int THR_W  = 4 + UNIT_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              us_tick,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [7:0]        cfg,
    output logic              jam_req,
    output logic              busy
);

    jam_state_e       st_q;
    jam_state_e       st_d;
    logic [THR_W-1:0] thr_bytes;
    logic [CNT_W-1:0] dur_ticks;
    logic [CNT_W-1:0] cnt;
    logic             below;
    logic             done;
    logic             is_jam;
    logic             start;
    logic             rearm;
    logic             load;

    jam_cfg_decode #(.UNIT_LG(UNIT_LG)) u_dec (
        .cfg       (cfg),
        .thr_bytes (thr_bytes),
        .dur_ticks (dur_ticks)
    );

    jam_level_cmp #(.FREE_W(FREE_W), .THR_W(THR_W)) u_cmp (
        .free_bytes (free_bytes),
        .thr_bytes  (thr_bytes),
        .below      (below)
    );

    jam_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .load     (load),
        .load_val (dur_ticks),
        .run      (is_jam),
        .tick     (us_tick),
        .cnt      (cnt),
        .done     (done)
    );

    // Decide when a period starts or restarts.
    always_comb begin
        is_jam = (st_q == ST_JAM);
        start  = en && !is_jam && below;
        rearm  = en && done && below;
        load   = start || rearm;
    end

    // Next-state logic for idle and jam.
    always_comb begin
        st_d = st_q;
        if (!en)
            st_d = ST_IDLE;
        else if (start)
            st_d = ST_JAM;
        else if (done && !below)
            st_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Drive outputs; enable gates the jam request with no delay.
    always_comb begin
        jam_req = is_jam && en;
        busy    = en && (is_jam || below);
    end

endmodule

// File: rtl/jam_ctrl_chk.sv
// Property checker for bp_jam_ctrl, attached by bind to the internal state and counter.
// Assumes synchronous active-low reset.
module jam_ctrl_chk
    import jam_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             us_tick,
    input logic [7:0]       cfg,
    input logic             below,
    input logic             is_jam,
    input logic [CNT_W-1:0] cnt,
    input logic             jam_req,
    input logic             busy
);

    // R8
    jam_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req |-> en);

    // R8
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !is_jam);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jam && en && !us_tick) |=> $stable(cnt));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_jam && en && below) |=> (is_jam && cnt == jam_time_us($past(cfg[3:0]))));

    // R6
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_jam && !below) |=> !is_jam);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req |-> busy);

    // R3
    cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(JAM_MAX_US));

endmodule

bind bp_jam_ctrl jam_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .us_tick (us_tick),
    .cfg     (cfg),
    .below   (below),
    .is_jam  (is_jam),
    .cnt     (cnt),
    .jam_req (jam_req),
    .busy    (busy)
);

// File: tb/tb_bp_jam_ctrl.sv
module tb_bp_jam_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        us_tick = 1'b0;
    logic [15:0] free_bytes = 16'hFFFF;
    logic [7:0]  cfg = 8'h37;
    logic        jam_req;
    logic        busy;

    int vectors = 0;
    int fails = 0;
    bit done_flag = 0;

    bit m_jam = 0;
    int m_cnt = 0;
    bit jam_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_jam_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .us_tick    (us_tick),
        .free_bytes (free_bytes),
        .cfg        (cfg),
        .jam_req    (jam_req),
        .busy       (busy)
    );

    function automatic int ref_dur(input logic [3:0] c);
        case (c)
            4'd0: return 5;    4'd1: return 10;   4'd2: return 15;   4'd3: return 25;
            4'd4: return 50;   4'd5: return 100;  4'd6: return 150;  4'd7: return 200;
            4'd8: return 250;  4'd9: return 300;  4'd10: return 350; 4'd11: return 400;
            4'd12: return 450; 4'd13: return 500; 4'd14: return 550; default: return 600;
        endcase
    endfunction

    function automatic bit ref_below(input logic [15:0] f, input logic [7:0] c);
        return int'(f) < int'(c[7:4]) * 1024;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: apply inputs at negedge, compare outputs, then advance model at posedge.
    task automatic step(input logic e, input logic [15:0] f, input logic [7:0] c,
                        input logic t, input string tag);
        bit b;
        en = e; free_bytes = f; cfg = c; us_tick = t;
        #1;
        b = ref_below(f, c);
        check(tag, int'(jam_req), int'(m_jam && e), "jam_req");
        check(tag, int'(busy), int'(e && (m_jam || b)), "busy");
        jam_seen = jam_req;
        @(posedge clk);
        if (!e) begin
            m_jam = 0; m_cnt = 0;
        end else if (!m_jam) begin
            if (b) begin m_jam = 1; m_cnt = ref_dur(c[3:0]); end
        end else if (t) begin
            if (m_cnt == 1) begin
                if (b) m_cnt = ref_dur(c[3:0]);
                else begin m_jam = 0; m_cnt = 0; end
            end else m_cnt--;
        end
        @(negedge clk);
    endtask

    // Measure one isolated period with a tick every cycle.
    task automatic measure(input logic [3:0] code);
        int n;
        n = 0;
        step(1, 16'd100, {4'd3, code}, 1, "R3");
        for (int i = 0; i < 700; i++) begin
            step(1, 16'hFFFF, {4'd3, code}, 1, "R3");
            if (!jam_seen) break;
            n++;
        end
        check("R3", n, ref_dur(code), "period length");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10", int'(jam_req), 0, "jam_req in reset");
        rst_n = 1'b1;
        step(1, 16'hFFFF, 8'h37, 0, "R10");

        // R3: period lengths across the scale
        measure(4'd0);
        measure(4'd3);
        measure(4'd4);
        measure(4'd7);
        measure(4'd15);

        // R1: equal to threshold does not start, one byte under does
        step(1, 16'd3072, 8'h30, 1, "R1");
        step(1, 16'd3072, 8'h30, 1, "R1");
        check("R1", int'(jam_seen), 0, "no jam at equality");
        step(1, 16'd3071, 8'h30, 1, "R1");
        step(1, 16'hFFFF, 8'h30, 1, "R1");
        check("R1", int'(jam_seen), 1, "jam one byte under");
        for (int i = 0; i < 8; i++) step(1, 16'hFFFF, 8'h30, 1, "R6");
        check("R6", int'(jam_seen), 0, "idle after period");

        // R2: zero threshold never jams
        for (int i = 0; i < 10; i++) step(1, 16'd0, 8'h00, 1, "R2");
        check("R2", int'(jam_seen), 0, "zero threshold");

        // R4: sparse ticks, length in cycles
        step(1, 16'd10, 8'h30, 0, "R4");
        for (int i = 0; i < 12; i++) step(1, 16'hFFFF, 8'h30, 1'(i % 3 == 2), "R4");
        check("R4", int'(jam_seen), 1, "still jamming after 4 ticks");
        for (int i = 0; i < 6; i++) step(1, 16'hFFFF, 8'h30, 1'(i % 3 == 2), "R4");
        check("R4", int'(jam_seen), 0, "ended after 5 ticks");

        // R5: continuous shortage keeps jam high across periods
        for (int i = 0; i < 20; i++) begin
            step(1, 16'd5, 8'h30, 1, "R5");
            if (i > 0) check("R5", int'(jam_seen), 1, "no gap on re-arm");
        end
        for (int i = 0; i < 8; i++) step(1, 16'hFFFF, 8'h30, 1, "R6");

        // R7: code change mid-period; first period keeps code 0 length
        step(1, 16'd5, 8'h30, 1, "R7");
        for (int i = 0; i < 4; i++) step(1, 16'hFFFF, 8'h3F, 1, "R7");
        step(1, 16'hFFFF, 8'h3F, 1, "R7");
        check("R7", int'(jam_seen), 1, "fifth sample high");
        step(1, 16'hFFFF, 8'h3F, 1, "R7");
        check("R7", int'(jam_seen), 0, "period kept old length");

        // R8: enable dropped mid-jam
        step(1, 16'd5, 8'h37, 1, "R8");
        step(1, 16'd5, 8'h37, 1, "R8");
        step(0, 16'd5, 8'h37, 1, "R8");
        check("R8", int'(jam_seen), 0, "jam drops with en");
        step(0, 16'd5, 8'h37, 1, "R8");
        step(1, 16'hFFFF, 8'h37, 1, "R8");
        check("R8", int'(jam_seen), 0, "idle after re-enable");

        // R9 and all others: constrained random against the model
        begin
            logic [7:0] c = 8'h37;
            for (int i = 0; i < 40000; i++) begin
                int f;
                logic e;
                if ($urandom % 500 == 0) c = {4'($urandom % 16), 4'($urandom % 8)};
                f = int'(c[7:4]) * 1024 + int'($urandom % 400) - 200;
                if (f < 0) f = 0;
                e = ($urandom % 300) != 0;
                step(e, 16'(f), c, 1'($urandom % 2 == 0), "R9");
            end
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule